// File: doc/BRIEF.md
# DMA Staging FIFO with Residual Byte Count

This block is a byte-granular staging buffer between a source bus that pushes data and a sink bus that drains it. Each cycle the source may offer one to eight bytes on the low lanes of a 64-bit word, and the sink may take one to eight bytes. Storage is 118 rows of eight bytes. A mode bit selects whether only 112 bytes or all 944 bytes are usable.

Two counters run beside the data. A transfer counter is loaded with the length of a transfer and counts down by every byte the FIFO accepts. A tally counter counts down by every byte the sink takes. Loading the transfer counter realigns the tally to the new load value plus the bytes already held. When an operation stops, software subtracts the low bits of the transfer counter from the tally and masks the result to the mode width. The difference is the number of bytes still stranded in the buffer. The block presents that residual directly, next to both counters.

Top module: `dma_stage_fifo`

## Requirements
- R1: After reset the occupancy, tally, transfer counter and residual are all zero and the small (112-byte) mode is selected.
- R2: A write is accepted (`wr_ack_o` high) only when clear is low, no mode change takes effect that cycle, `wr_cnt_i` is between 1 and 8, and occupancy plus `wr_cnt_i` does not exceed the capacity. Lanes 0 to `wr_cnt_i`-1 of `wr_data_i` are stored in lane order, and the occupancy grows by `wr_cnt_i`.
- R3: A read is accepted (`rd_ack_o` high) only when clear is low, `rd_cnt_i` is between 1 and 8, and `rd_cnt_i` does not exceed the occupancy. Byte lane k of `rd_data_o` (bits 8k+7:8k) always shows the k-th oldest held byte, for k below the occupancy.
- R4: A load sets the transfer counter to `bc_val_i`. Every accepted write then lowers it by `wr_cnt_i`, modulo 2^24. When a load and a write coincide, the counter becomes the load value minus the written bytes.
- R5: Every accepted read lowers the tally by `rd_cnt_i`, modulo 1024. A load sets the tally to `bc_val_i` plus the occupancy held before that cycle, and a read in the same cycle is then subtracted. `tally_o` shows the low 7 bits in small mode and the low 10 bits in large mode.
- R6: `resid_o` equals (tally minus the low 10 bits of the transfer counter) masked with 0x7F in small mode and with 0x3FF in large mode, and it always equals the occupancy.
- R7: `big_mode_i` (0 = 112 bytes, 1 = 944 bytes) takes effect only in a cycle where the occupancy is zero. In that cycle a write is refused. A differing value while bytes are held is ignored.
- R8: Clear empties the FIFO and leaves the transfer counter unchanged, except for a load in the same cycle. It sets the tally to the low bits of the transfer counter, so the residual becomes zero. Writes and reads are refused during clear.
- R9: Exactly 112 bytes (small mode) or 944 bytes (large mode) can be held. Any further write is refused.
- R10: Storage wraps at the capacity boundary, and the byte order is preserved across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous FIFO clear |
| big_mode_i | input | 1 | Requested size mode, 1 = 944 bytes |
| wr_cnt_i | input | 4 | Bytes offered on the low lanes (0 = none) |
| wr_data_i | input | 64 | Write data, lane k in bits 8k+7:8k |
| wr_ack_o | output | 1 | Write accepted this cycle |
| rd_cnt_i | input | 4 | Bytes requested by the sink (0 = none) |
| rd_data_o | output | 64 | Oldest eight held bytes, oldest in lane 0 |
| rd_ack_o | output | 1 | Read accepted this cycle |
| bc_load_i | input | 1 | Load the transfer counter |
| bc_val_i | input | 24 | Transfer length to load |
| level_o | output | 10 | Bytes currently held |
| big_mode_o | output | 1 | Active size mode |
| tally_o | output | 10 | Tally counter, masked to the mode width |
| xfer_cnt_o | output | 24 | Transfer byte counter |
| resid_o | output | 10 | Residual byte count |

## Verification
A write and a read can be accepted in the same cycle. A counter load can land in that same cycle too. This gives the transfer counter and the tally an update from two directions at once, and the bench provokes it on purpose. The bench runs long streams of simultaneous pushes and pops of different sizes, with loads dropped in between. Each cycle, a byte-queue model in the bench predicts both acknowledges, the lane data, both counters and the occupancy. The residual output must equal the model's occupancy after every edge. The bench also times a clear and a mode request to coincide with a write, to check the stated precedence.

// File: rtl/dma_stage_pkg.sv
package dma_stage_pkg;

  typedef enum logic {
    SIZE_SMALL = 1'b0,
    SIZE_LARGE = 1'b1
  } size_mode_e;

  // advance a ring index by off, wrapping at cap (off < cap assumed)
  function automatic int unsigned ring_step(int unsigned ptr, int unsigned off,
                                            int unsigned cap);
    int unsigned s;
    s = ptr + off;
    return (s >= cap) ? s - cap : s;
  endfunction

endpackage

// File: rtl/dfifo_store.sv
module dfifo_store #(
  parameter int unsigned LANES = 8,
  parameter int unsigned DEPTH = 944,
  parameter int unsigned AW    = 10,
  parameter int unsigned CW    = 4
) (
  input  logic               clk_i,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_ptr_i,
  input  logic [CW-1:0]      wr_cnt_i,
  input  logic [8*LANES-1:0] wr_data_i,
  input  logic [AW-1:0]      rd_ptr_i,
  input  logic [AW-1:0]      cap_i,
  output logic [8*LANES-1:0] rd_data_o
);
  import dma_stage_pkg::*;

  // no parity on the storage
  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] wr_addr [LANES];
  logic [AW-1:0] rd_addr [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_addr[g] = AW'(ring_step(int'(wr_ptr_i), g, int'(cap_i)));
    assign rd_addr[g] = AW'(ring_step(int'(rd_ptr_i), g, int'(cap_i)));
    assign rd_data_o[8*g +: 8] = mem_q[rd_addr[g]];
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int i = 0; i < LANES; i++) begin
        if (i < int'(wr_cnt_i)) mem_q[wr_addr[i]] <= wr_data_i[8*i +: 8];
      end
    end
  end

endmodule

// File: rtl/dfifo_ctrl.sv
module dfifo_ctrl #(
  parameter int unsigned LANES       = 8,
  parameter int unsigned DEPTH       = 944,
  parameter int unsigned SMALL_BYTES = 112,
  parameter int unsigned AW          = 10,
  parameter int unsigned CW          = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          big_mode_i,
  input  logic [CW-1:0] wr_cnt_i,
  input  logic [CW-1:0] rd_cnt_i,
  output logic          wr_ack_o,
  output logic          rd_ack_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [AW-1:0] level_o,
  output logic [AW-1:0] cap_o,
  output logic          big_mode_o
);
  import dma_stage_pkg::*;

  size_mode_e    mode_q;
  logic [AW-1:0] level_q, wr_ptr_q, rd_ptr_q;
  logic [AW-1:0] wr_ptr_d, rd_ptr_d, level_d;
  logic          mode_chg, wr_cnt_ok, rd_cnt_ok, room;
  logic [AW:0]   level_sum;

  assign cap_o     = (mode_q == SIZE_LARGE) ? AW'(DEPTH) : AW'(SMALL_BYTES);
  assign mode_chg  = (level_q == '0) && (big_mode_i != mode_q);
  assign wr_cnt_ok = (wr_cnt_i != '0) && (wr_cnt_i <= CW'(LANES));
  assign rd_cnt_ok = (rd_cnt_i != '0) && (rd_cnt_i <= CW'(LANES));
  assign level_sum = {1'b0, level_q} + (AW+1)'(wr_cnt_i);
  assign room      = level_sum <= {1'b0, cap_o};

  assign wr_ack_o  = !clr_i && !mode_chg && wr_cnt_ok && room;
  assign rd_ack_o  = !clr_i && rd_cnt_ok && (AW'(rd_cnt_i) <= level_q);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (wr_ack_o) begin
      wr_ptr_d = AW'(ring_step(int'(wr_ptr_q), int'(wr_cnt_i), int'(cap_o)));
      level_d  = level_d + AW'(wr_cnt_i);
    end
    if (rd_ack_o) begin
      rd_ptr_d = AW'(ring_step(int'(rd_ptr_q), int'(rd_cnt_i), int'(cap_o)));
      level_d  = level_d - AW'(rd_cnt_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= SIZE_SMALL;
      level_q  <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (clr_i) begin
      level_q  <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (mode_chg) begin
      mode_q   <= size_mode_e'(big_mode_i);
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      level_q  <= level_d;
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  assign wr_ptr_o   = wr_ptr_q;
  assign rd_ptr_o   = rd_ptr_q;
  assign level_o    = level_q;
  assign big_mode_o = (mode_q == SIZE_LARGE);

  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= cap_o);
  a_r3_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack_o |-> (AW'(rd_cnt_i) <= level_q));
  a_r7_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q != '0) |=> $stable(mode_q));
  a_r8_clear_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (level_q == '0));

endmodule

// File: rtl/dfifo_resid.sv
module dfifo_resid #(
  parameter int unsigned AW      = 10,
  parameter int unsigned CW      = 4,
  parameter int unsigned BC_W    = 24,
  parameter int unsigned SMALL_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            big_mode_i,
  input  logic [AW-1:0]   level_i,
  input  logic            wr_ack_i,
  input  logic [CW-1:0]   wr_cnt_i,
  input  logic            rd_ack_i,
  input  logic [CW-1:0]   rd_cnt_i,
  input  logic            bc_load_i,
  input  logic [BC_W-1:0] bc_val_i,
  output logic [AW-1:0]   tally_o,
  output logic [BC_W-1:0] xfer_o,
  output logic [AW-1:0]   resid_o
);

  localparam logic [AW-1:0] SMALL_MASK = AW'((1 << SMALL_W) - 1);

  logic [BC_W-1:0] xfer_q, xfer_base, xfer_d;
  logic [AW-1:0]   tally_q, tally_base, tally_d;
  logic [AW-1:0]   w_n, r_n, mask;

  assign w_n = wr_ack_i ? AW'(wr_cnt_i) : '0;
  assign r_n = rd_ack_i ? AW'(rd_cnt_i) : '0;

  assign xfer_base  = bc_load_i ? bc_val_i : xfer_q;
  assign xfer_d     = xfer_base - BC_W'(w_n);
  // load realigns the tally so that tally - xfer keeps equal to occupancy
  assign tally_base = bc_load_i ? (bc_val_i[AW-1:0] + level_i) : tally_q;
  assign tally_d    = clr_i ? xfer_d[AW-1:0] : (tally_base - r_n);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_q  <= '0;
      tally_q <= '0;
    end else begin
      xfer_q  <= xfer_d;
      tally_q <= tally_d;
    end
  end

  assign mask    = big_mode_i ? '1 : SMALL_MASK;
  assign tally_o = tally_q & mask;
  assign xfer_o  = xfer_q;
  assign resid_o = (tally_q - xfer_q[AW-1:0]) & mask;

  a_r6_resid_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resid_o == level_i);
  a_r4_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bc_load_i && !wr_ack_i) |=> (xfer_q == $past(bc_val_i)));
  a_r8_clear_keeps_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !bc_load_i) |=> $stable(xfer_q));
  a_r5_tally_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ack_i && !bc_load_i) |=> (tally_q == $past(tally_q) - AW'($past(rd_cnt_i))));

endmodule

// File: rtl/dma_stage_fifo.sv
module dma_stage_fifo #(
  parameter int unsigned LANES       = 8,
  parameter int unsigned ENTRIES     = 118,
  parameter int unsigned SMALL_BYTES = 112,
  parameter int unsigned BC_W        = 24,
  localparam int unsigned DEPTH      = LANES * ENTRIES,
  localparam int unsigned AW         = $clog2(DEPTH + 1),
  localparam int unsigned CW         = $clog2(LANES + 1),
  localparam int unsigned SMALL_W    = $clog2(SMALL_BYTES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               big_mode_i,
  input  logic [CW-1:0]      wr_cnt_i,
  input  logic [8*LANES-1:0] wr_data_i,
  output logic               wr_ack_o,
  input  logic [CW-1:0]      rd_cnt_i,
  output logic [8*LANES-1:0] rd_data_o,
  output logic               rd_ack_o,
  input  logic               bc_load_i,
  input  logic [BC_W-1:0]    bc_val_i,
  output logic [AW-1:0]      level_o,
  output logic               big_mode_o,
  output logic [AW-1:0]      tally_o,
  output logic [BC_W-1:0]    xfer_cnt_o,
  output logic [AW-1:0]      resid_o
);

  logic [AW-1:0] wr_ptr, rd_ptr, cap;

  dfifo_ctrl #(
    .LANES(LANES), .DEPTH(DEPTH), .SMALL_BYTES(SMALL_BYTES), .AW(AW), .CW(CW)
  ) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .big_mode_i (big_mode_i),
    .wr_cnt_i   (wr_cnt_i),
    .rd_cnt_i   (rd_cnt_i),
    .wr_ack_o   (wr_ack_o),
    .rd_ack_o   (rd_ack_o),
    .wr_ptr_o   (wr_ptr),
    .rd_ptr_o   (rd_ptr),
    .level_o    (level_o),
    .cap_o      (cap),
    .big_mode_o (big_mode_o)
  );

  dfifo_store #(
    .LANES(LANES), .DEPTH(DEPTH), .AW(AW), .CW(CW)
  ) i_store (
    .clk_i     (clk_i),
    .wr_en_i   (wr_ack_o),
    .wr_ptr_i  (wr_ptr),
    .wr_cnt_i  (wr_cnt_i),
    .wr_data_i (wr_data_i),
    .rd_ptr_i  (rd_ptr),
    .cap_i     (cap),
    .rd_data_o (rd_data_o)
  );

  dfifo_resid #(
    .AW(AW), .CW(CW), .BC_W(BC_W), .SMALL_W(SMALL_W)
  ) i_resid (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .big_mode_i (big_mode_o),
    .level_i    (level_o),
    .wr_ack_i   (wr_ack_o),
    .wr_cnt_i   (wr_cnt_i),
    .rd_ack_i   (rd_ack_o),
    .rd_cnt_i   (rd_cnt_i),
    .bc_load_i  (bc_load_i),
    .bc_val_i   (bc_val_i),
    .tally_o    (tally_o),
    .xfer_o     (xfer_cnt_o),
    .resid_o    (resid_o)
  );

endmodule

// File: tb/test_dma_stage_fifo.sv
module test_dma_stage_fifo;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0;
  logic        big_mode_i = 1'b0;
  logic [3:0]  wr_cnt_i = '0;
  logic [63:0] wr_data_i = '0;
  logic        wr_ack_o;
  logic [3:0]  rd_cnt_i = '0;
  logic [63:0] rd_data_o;
  logic        rd_ack_o;
  logic        bc_load_i = 1'b0;
  logic [23:0] bc_val_i = '0;
  logic [9:0]  level_o;
  logic        big_mode_o;
  logic [9:0]  tally_o;
  logic [23:0] xfer_cnt_o;
  logic [9:0]  resid_o;

  dma_stage_fifo i_dma_stage_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .big_mode_i(big_mode_i),
    .wr_cnt_i(wr_cnt_i), .wr_data_i(wr_data_i), .wr_ack_o(wr_ack_o),
    .rd_cnt_i(rd_cnt_i), .rd_data_o(rd_data_o), .rd_ack_o(rd_ack_o),
    .bc_load_i(bc_load_i), .bc_val_i(bc_val_i), .level_o(level_o),
    .big_mode_o(big_mode_o), .tally_o(tally_o), .xfer_cnt_o(xfer_cnt_o),
    .resid_o(resid_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_checks = 0;
  int n_fails  = 0;

  // bench model
  logic [7:0]  q[$];
  logic [23:0] m_xfer = '0;
  logic [9:0]  m_tally = '0;
  bit          m_big = 1'b0;
  int          seq = 0;
  bit          last_wack, last_rack;

  function automatic logic [7:0] byte_of(int s);
    return 8'((s * 37 + 11) & 8'hFF);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(int wc, int rc, bit ld, logic [23:0] lv, bit cl, bit md);
    int  cap, wn, rn, lvl;
    bit  mchg, ewa, era;
    logic [9:0] msk;
    @(negedge clk_i);
    wr_cnt_i = 4'(wc);
    rd_cnt_i = 4'(rc);
    bc_load_i = ld;
    bc_val_i = lv;
    clr_i = cl;
    big_mode_i = md;
    for (int k = 0; k < 8; k++) wr_data_i[8*k +: 8] = byte_of(seq + k);
    #1;
    lvl  = q.size();
    cap  = m_big ? 944 : 112;
    mchg = (lvl == 0) && (md != m_big);
    ewa  = !cl && !mchg && wc >= 1 && wc <= 8 && (lvl + wc <= cap);
    era  = !cl && rc >= 1 && rc <= 8 && rc <= lvl;
    chk("R2", "wr_ack", wr_ack_o, ewa);
    chk("R3", "rd_ack", rd_ack_o, era);
    for (int k = 0; k < 8 && k < lvl; k++)
      chk("R3", "rd_data lane", rd_data_o[8*k +: 8], q[k]);
    last_wack = ewa;
    last_rack = era;
    @(posedge clk_i);
    wn = ewa ? wc : 0;
    rn = era ? rc : 0;
    m_xfer = (ld ? lv : m_xfer) - 24'(wn);
    if (cl) m_tally = m_xfer[9:0];
    else m_tally = (ld ? (lv[9:0] + 10'(lvl)) : m_tally) - 10'(rn);
    if (cl) q.delete();
    else begin
      for (int k = 0; k < rn; k++) void'(q.pop_front());
      for (int k = 0; k < wn; k++) q.push_back(byte_of(seq + k));
    end
    seq += wn;
    if (!cl && mchg) m_big = md;
    #1;
    msk = m_big ? 10'h3FF : 10'h07F;
    chk("R2", "level", level_o, q.size());
    chk("R4", "xfer_cnt", xfer_cnt_o, m_xfer);
    chk("R5", "tally", tally_o, m_tally & msk);
    chk("R6", "resid", resid_o, 10'((m_tally - m_xfer[9:0]) & msk));
    chk("R6", "resid=level", resid_o, q.size());
    chk("R7", "mode", big_mode_o, m_big);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    #(CLK_PERIOD * 2);
    chk("R1", "level", level_o, 0);
    chk("R1", "tally", tally_o, 0);
    chk("R1", "xfer", xfer_cnt_o, 0);
    chk("R1", "resid", resid_o, 0);
    chk("R1", "mode", big_mode_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_fill_small();
    step(0, 0, 1, 24'd300, 0, 0);
    for (int i = 0; i < 14; i++) step(8, 0, 0, '0, 0, 0);
    chk("R9", "small full level", level_o, 112);
    step(1, 0, 0, '0, 0, 0);
    chk("R9", "write past 112 refused", last_wack, 0);
    step(9, 0, 0, '0, 0, 0);
    chk("R2", "wr_cnt 9 refused", last_wack, 0);
  endtask

  task automatic t_drain_small();
    step(0, 3, 0, '0, 0, 0);
    step(0, 5, 0, '0, 0, 0);
    for (int i = 0; i < 13; i++) step(0, 8, 0, '0, 0, 0);
    step(0, 8, 0, '0, 0, 0);   // only 0 left
    chk("R3", "read on empty refused", last_rack, 0);
  endtask

  task automatic t_mode();
    step(4, 0, 0, '0, 0, 0);
    step(2, 0, 0, '0, 0, 1);   // change requested while holding bytes
    chk("R7", "mode ignored while non-empty", big_mode_o, 0);
    step(0, 6, 0, '0, 0, 1);
    chk("R7", "mode still small at drain edge", big_mode_o, 0);
    step(8, 0, 0, '0, 0, 1);   // empty: change applies, write refused
    chk("R7", "write refused on mode change", last_wack, 0);
    chk("R7", "mode now large", big_mode_o, 1);
  endtask

  task automatic t_fill_big();
    step(0, 0, 1, 24'h012345, 0, 1);
    for (int i = 0; i < 118; i++) step(8, 0, 0, '0, 0, 1);
    chk("R9", "large full level", level_o, 944);
    step(1, 0, 0, '0, 0, 1);
    chk("R9", "write past 944 refused", last_wack, 0);
  endtask

  task automatic t_concurrent();
    // large mode, full: drain some, then mixed traffic with loads
    for (int i = 0; i < 40; i++) step(0, 8, 0, '0, 0, 1);
    for (int i = 0; i < 60; i++) begin
      bit ld = (i % 17) == 5;
      step(1 + (i % 8), 1 + ((i * 3) % 8), ld, 24'(i * 1000 + 7), 0, 1);
      chk("R4", "both accepted", last_wack && last_rack, 1);
    end
  endtask

  task automatic t_wrap();
    // stream across the 944-byte boundary several times
    for (int i = 0; i < 400; i++) step(7, 7, 0, '0, 0, 1);
    chk("R10", "level after wrapping stream", level_o, q.size());
    chk("R10", "oldest byte after wrap", rd_data_o[7:0], q[0]);
  endtask

  task automatic t_clear();
    step(3, 2, 1, 24'h000500, 1, 1);
    chk("R8", "clear empties", level_o, 0);
    chk("R8", "clear residual zero", resid_o, 0);
    chk("R8", "load applies with clear", xfer_cnt_o, 24'h000500);
    step(5, 0, 0, '0, 0, 1);
    step(0, 0, 0, '0, 1, 1);
    chk("R8", "xfer kept on clear", xfer_cnt_o, 24'h0004FB);
    step(0, 0, 0, '0, 0, 0);   // back to small while empty
    // small-mode wrap with pointer crossing 112
    for (int i = 0; i < 60; i++) step(5, (i < 10) ? 0 : 5, 0, '0, 0, 0);
    chk("R10", "small wrap oldest byte", rd_data_o[7:0], q[0]);
    step(0, 0, 1, 24'h00FF80, 0, 0);
    chk("R5", "tally on load masked", tally_o, (10'h380 + 10'(q.size())) & 10'h07F);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_fill_small();
    t_drain_small();
    t_mode();
    t_fill_big();
    t_concurrent();
    t_wrap();
    t_clear();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule